// File: doc/BRIEF.md
# Expansion-Bus Interrupt Merger with Rearm Gap

The block collects eight level-sensitive interrupt request lines from an expansion bus and presents them to a host processor as one status register and one combined interrupt pin. Each line is passed through a synchroniser. A rising edge on a line latches the matching status bit. The combined pin is high while any status bit is set. Input bit i feeds status bit i. In bit order 0 to 7 the lines carry bus request levels 3, 4, 5, 6, 7, 10, 11 and 12.

The host reads the register to find which sources are pending. It acknowledges a source by writing 1 to that bit. Clearing a bit pulls the combined pin low. The pin is then held low for a fixed number of clock cycles (`GAP_CYCLES`) before it may rise again for any source still pending. This gives the host a fresh edge for every serviced source, and the low time is long enough for an edge-triggered host input. For example, 30 cycles at 100 MHz gives 300 ns, which is inside a 250 to 375 ns window and above a 154 ns minimum inactive time.

The register is 16 bits wide. Only the low byte carries data. There is no address: the one register is always readable, and a write takes effect when the write strobe is high at a clock edge.

Top module: `irq_merge_gap`

## Requirements
- R1: After synchronous reset, all status bits read 0 and `irq_out` is 0.
- R2: A 0-to-1 change on `irq_in[i]` sets status bit i (`reg_rdata[i]`). The change becomes visible after the third rising clock edge that follows it. Bits 0..7 carry bus levels 3, 4, 5, 6, 7, 10, 11, 12 in that order.
- R3: A line that stays high after its bit has been cleared does not set the bit again. Only a new rising edge sets it.
- R4: A write with `reg_wr`=1 clears every status bit whose `reg_wdata[i]` is 1. Bits written with 0 keep their value.
- R5: `reg_rdata[15:8]` always reads 0. `reg_wdata[15:8]` has no effect on status or on `irq_out`.
- R6: Outside a rearm gap, `irq_out` is 1 exactly when at least one status bit is set. It changes at the same edge as the status bits.
- R7: A write that clears at least one set bit starts a rearm gap at that edge. `irq_out` is 0 for exactly `GAP_CYCLES` cycles after that edge. At the `GAP_CYCLES`-th following edge it rises if any bit is still set. A further clear during the gap restarts the gap.
- R8: If a rising edge and a write-1-to-clear reach the same bit at the same clock edge, the bit stays set, and that clear alone does not start a gap.
- R9: A write whose 1 bits match no set status bit changes nothing and does not start a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Raw asynchronous request lines; bit i maps to status bit i |
| reg_wr | input | 1 | Write strobe for the status register |
| reg_wdata | input | 16 | Write data; a 1 in bits 7..0 clears that status bit |
| reg_rdata | output | 16 | Status register: pending bits in 7..0, zero in 15..8 |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The bench sweeps all 256 patterns of simultaneously rising lines. Each pattern is paired with a computed clear mask. This tells apart a bit-order fault, a wrong clear mask, and a gap started when nothing was cleared.

For every clear that removes a bit, the pin is sampled at the last edge of the gap and at the first edge after it. This separates a gap that is too short or too long from a pin that fails to come back for the sources still pending.

Directed patterns cover the remaining cases:
- a line held high after its clear;
- a write to the upper byte only;
- a rising edge that lands on the same edge as its own clear.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

    localparam int SRC_COUNT   = 8;
    localparam int REG_WIDTH   = 16;
    localparam int SYNC_DEPTH  = 2;

    typedef struct packed {
        logic                 en;
        logic [SRC_COUNT-1:0] mask;
    } clr_req_t;

    typedef struct packed {
        logic [SRC_COUNT-1:0] bits;
        logic                 dropped;
    } stat_upd_t;

    function automatic logic [REG_WIDTH-1:0] pack_status(input logic [SRC_COUNT-1:0] s);
        return {{(REG_WIDTH-SRC_COUNT){1'b0}}, s};
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N_SRC  = irq_merge_pkg::SRC_COUNT,
    parameter int STAGES = irq_merge_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] rise
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        logic [STAGES:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-1:0], raw[i]};
        end
        assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_merge_pkg::*;
#(
    parameter int N_SRC = SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] rise,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] status_next,
    output logic             dropped
);
    logic [N_SRC-1:0] clr_eff;

    always_comb begin
        clr_eff     = clr_en ? clr_mask : '0;
        status_next = (status & ~clr_eff) | rise;
        dropped     = |(status & clr_eff & ~rise);
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_next;
    end
endmodule

// File: rtl/rearm_gap_timer.sv
module rearm_gap_timer #(
    parameter int GAP_CYCLES = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic idle_next
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt, cnt_next;

    always_comb begin
        if (start)          cnt_next = CW'(GAP_CYCLES);
        else if (cnt != '0) cnt_next = cnt - 1'b1;
        else                cnt_next = '0;
        idle_next = (cnt_next == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end
endmodule

// File: rtl/irq_merge_gap.sv
module irq_merge_gap
    import irq_merge_pkg::*;
#(
    parameter int N_SRC      = SRC_COUNT,
    parameter int DATA_W     = REG_WIDTH,
    parameter int GAP_CYCLES = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    logic [N_SRC-1:0] rise;
    clr_req_t         req;
    stat_upd_t        upd;
    logic [N_SRC-1:0] status;
    logic             idle_next;
    logic             irq_q;

    assign req.en   = reg_wr;
    assign req.mask = reg_wdata[N_SRC-1:0];

    irq_edge_sync #(.N_SRC(N_SRC), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .raw(irq_in), .rise(rise)
    );

    irq_status_bank #(.N_SRC(N_SRC)) u_bank (
        .clk(clk), .rst(rst), .rise(rise),
        .clr_en(req.en), .clr_mask(req.mask),
        .status(status), .status_next(upd.bits), .dropped(upd.dropped)
    );

    rearm_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst(rst), .start(upd.dropped), .idle_next(idle_next)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (|upd.bits) & idle_next;
    end

    assign irq_out   = irq_q;
    assign reg_rdata = {{(DATA_W-N_SRC){1'b0}}, status};
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
    parameter int N_SRC      = 8,
    parameter int DATA_W     = 16,
    parameter int GAP_CYCLES = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic             prev_rst;
    logic             prev_wr;
    logic [N_SRC-1:0] prev_mask;
    logic [N_SRC-1:0] prev_stat;
    logic [CW-1:0]    gcnt;
    logic             fell;
    logic             in_gap;

    initial assert (GAP_CYCLES >= 1) else $error("gap must be at least one cycle"); // R7

    assign fell   = prev_wr & (|(prev_mask & prev_stat & ~reg_rdata[N_SRC-1:0]));
    assign in_gap = fell | (gcnt != '0);

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst) begin
            prev_wr   <= 1'b0;
            prev_mask <= '0;
            prev_stat <= '0;
            gcnt      <= '0;
        end else begin
            prev_wr   <= reg_wr;
            prev_mask <= reg_wdata[N_SRC-1:0];
            prev_stat <= reg_rdata[N_SRC-1:0];
            if (fell)            gcnt <= CW'(GAP_CYCLES - 1);
            else if (gcnt != '0) gcnt <= gcnt - 1'b1;
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (reg_rdata[N_SRC-1:0] == '0 && !irq_out)); // R1

    AST_UNWRITTEN_KEPT: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> (($past(reg_rdata[N_SRC-1:0]) & ~reg_rdata[N_SRC-1:0]) == '0)); // R4

    AST_ZERO_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (($past(reg_rdata[N_SRC-1:0]) & ~$past(reg_wdata[N_SRC-1:0])
                     & ~reg_rdata[N_SRC-1:0]) == '0)); // R4

    AST_OUT_LOW_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> !irq_out); // R7

    AST_OUT_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
        !in_gap |-> (irq_out == (|reg_rdata[N_SRC-1:0]))); // R6

    AST_NO_GAP_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_wdata[N_SRC-1:0] & reg_rdata[N_SRC-1:0]) == '0 && irq_out)
        |=> irq_out); // R9
endmodule

bind irq_merge_gap irq_merge_chk #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
);

// File: tb/irq_merge_gap_test.sv
`timescale 1ns/1ps
module irq_merge_gap_test;
    localparam int N   = 8;
    localparam int W   = 16;
    localparam int GAP = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         irq_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_merge_gap #(.N_SRC(N), .DATA_W(W), .GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic cleanup;
        irq_in = '0;
        wr(16'h00FF);
        wait_n(GAP + 3);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk("R1 status", reg_rdata, 16'h0000);
        chk("R1 irq_out", {15'b0, irq_out}, 16'h0000);

        // R2 R4 R6 R7 R9 sweep over all rising patterns
        for (int p = 0; p < 256; p++) begin
            logic [7:0] m, ex;
            m  = 8'((p * 37 + 11) & 255);
            ex = 8'(p) & ~m;
            irq_in = 8'(p);
            wait_n(3);
            chk("R2 set pattern", reg_rdata, {8'h00, 8'(p)});
            chk("R6 out level", {15'b0, irq_out}, {15'b0, p != 0});
            wr({8'h00, m});
            chk("R4 masked clear", reg_rdata, {8'h00, ex});
            if ((8'(p) & m) != 0) begin
                chk("R7 drop", {15'b0, irq_out}, 16'h0000);
                wait_n(GAP - 1);
                chk("R7 gap end low", {15'b0, irq_out}, 16'h0000);
                wait_n(1);
                chk("R7 rearm", {15'b0, irq_out}, {15'b0, ex != 0});
            end else if (p != 0) begin
                chk("R9 no gap", {15'b0, irq_out}, 16'h0001);
            end
            cleanup();
        end

        // R5 upper byte ignored on write and zero on read
        irq_in = 8'h04;
        wait_n(3);
        wr(16'hFF00);
        chk("R5 status kept", reg_rdata, 16'h0004);
        chk("R5 out kept", {15'b0, irq_out}, 16'h0001);
        wait_n(2);
        chk("R5 out kept late", {15'b0, irq_out}, 16'h0001);
        cleanup();

        // R3 held line does not re-set
        irq_in = 8'h20;
        wait_n(3);
        wr(16'h0020);
        wait_n(GAP + 10);
        chk("R3 held line", reg_rdata, 16'h0000);
        chk("R3 out", {15'b0, irq_out}, 16'h0000);
        cleanup();

        // R8 set and clear on the same edge
        irq_in = 8'h02;
        wait_n(3);
        irq_in = 8'h00;
        wait_n(3);
        chk("R8 pending", reg_rdata, 16'h0002);
        irq_in = 8'h02;
        wait_n(2);
        wr(16'h0002);
        chk("R8 set wins", reg_rdata, 16'h0002);
        chk("R8 no gap", {15'b0, irq_out}, 16'h0001);
        wait_n(2);
        chk("R8 out steady", {15'b0, irq_out}, 16'h0001);
        cleanup();
        chk("R4 final clear", reg_rdata, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule